// File: doc/BRIEF.md
# DMA Operand Packing Buffer

This block is the 32-bit staging register that sits between the read half and the write half of a dual-address DMA transfer. Source reads arrive with one operand size and destination writes leave with another size. The buffer gathers several narrow reads into one wide write, or splits one wide read into several narrow writes. When both sizes match, it passes each operand straight through. The register has no address in the programmer's map. Only the DMA sequencer reaches it, through a read-data strobe and a write-accept strobe.

The sequencer looks at `rd_req_o` and `wr_ready_o` to decide which bus cycle to run next. Address generation and byte counting are done elsewhere. The buffer tracks only how many byte lanes it holds and how many it has already released. An abort input throws away a partly built or partly drained operand, so that the next transfer starts from an empty register.

Top module: `dma_pack_buf`

## Requirements
- R1: After reset, `rd_req_o` is 1, `wr_ready_o` is 0 and `wr_data_o` is zero.
- R2: Size codes are 2'b00 for byte, 2'b01 for word and 2'b10 or 2'b11 for long word. Operands are right-justified on both data buses: a byte uses bits [7:0], a word uses bits [15:0] and a long word uses bits [31:0]. Read-data bits above the source size are ignored, and `wr_data_o` bits above the destination size are zero.
- R3: When source and destination sizes are equal, one accepted read makes `wr_ready_o` high on the next cycle, and `wr_data_o` then carries the same operand.
- R4: When the source is narrower than the destination, dest/source reads are gathered before `wr_ready_o` rises. This happens on the cycle after the last read. The first operand read lands in the most significant part of the written operand.
- R5: When the source is wider than the destination, one read produces source/dest writes, and the most significant part is written first.
- R6: `rd_req_o` is 0 while the buffer holds data that has not been written. It returns to 1 on the cycle after the final write of the operand is accepted.
- R7: While `wr_ready_o` is 1 and `wr_accept_i` is 0, `wr_ready_o` and `wr_data_o` hold their values. While `rd_req_o` is 1 and `rd_valid_i` is 0, `rd_req_o` stays 1.
- R8: An `abort_i` pulse empties the buffer. On the next cycle `rd_req_o` is 1 and `wr_ready_o` is 0, and the next read fills from the most significant part again.
- R9: `rd_valid_i` is ignored while `rd_req_o` is 0, and `wr_accept_i` is ignored while `wr_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Synchronous discard of buffered data |
| src_size_i | input | 2 | Source operand size code |
| dst_size_i | input | 2 | Destination operand size code |
| rd_valid_i | input | 1 | Source read data is present this cycle |
| rd_data_i | input | 32 | Source read data, right-justified |
| wr_accept_i | input | 1 | Destination write is taken this cycle |
| wr_data_o | output | 32 | Destination write data, right-justified |
| wr_ready_o | output | 1 | A destination operand is available |
| rd_req_o | output | 1 | The next cycle should be a source read |

## Verification
The assertions assume that both size codes stay constant from the first read of an operand until its last write is accepted. The hold and pass-through properties depend on this, because the output lane selection follows the size inputs combinationally. The bench changes sizes only while the buffer is empty: either right after reset, after the final accepted write, or after an abort. Each scenario task drives its strobes on the falling edge, so every strobe is seen at exactly one rising edge.

// File: rtl/dpk_pkg.sv
package dpk_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE     = 2'b00,
      SZ_WORD     = 2'b01,
      SZ_LONG     = 2'b10,
      SZ_LONG_ALT = 2'b11
   } size_e;

   localparam int unsigned OPER_LANES = 4;
   localparam int unsigned CNT_W      = 3;

   function automatic logic [CNT_W-1:0] lanes_of(input logic [1:0] code);
      logic [CNT_W-1:0] n;
      case (size_e'(code))
         SZ_BYTE: n = 3'd1;
         SZ_WORD: n = 3'd2;
         default: n = 3'd4;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dpk_size_decode.sv
module dpk_size_decode
   import dpk_pkg::*;
(
   input  logic [1:0]       src_size_i,
   input  logic [1:0]       dst_size_i,
   output logic [CNT_W-1:0] src_lanes_o,
   output logic [CNT_W-1:0] dst_lanes_o,
   output logic [CNT_W-1:0] span_lanes_o
);

   always_comb begin
      src_lanes_o  = lanes_of(src_size_i);
      dst_lanes_o  = lanes_of(dst_size_i);
      span_lanes_o = (src_lanes_o > dst_lanes_o) ? src_lanes_o : dst_lanes_o;
   end

endmodule

// File: rtl/dpk_seq.sv
module dpk_seq
   import dpk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort_i,
   input  logic             rd_valid_i,
   input  logic             wr_accept_i,
   input  logic [CNT_W-1:0] src_lanes_i,
   input  logic [CNT_W-1:0] dst_lanes_i,
   input  logic [CNT_W-1:0] span_lanes_i,
   output logic [CNT_W-1:0] fill_cnt_o,
   output logic [CNT_W-1:0] rd_ptr_o,
   output logic             draining_o,
   output logic             rd_take_o,
   output logic             wr_take_o
);

   logic [CNT_W-1:0] fill_q, ptr_q;
   logic             drain_q;
   logic [CNT_W-1:0] fill_nx, ptr_nx;

   always_comb begin
      rd_take_o = rd_valid_i  && !drain_q;
      wr_take_o = wr_accept_i &&  drain_q;
      fill_nx   = fill_q + src_lanes_i;
      ptr_nx    = ptr_q  + dst_lanes_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q  <= '0;
         ptr_q   <= '0;
         drain_q <= 1'b0;
      end else if (abort_i) begin
         fill_q  <= '0;
         ptr_q   <= '0;
         drain_q <= 1'b0;
      end else if (rd_take_o) begin
         fill_q <= fill_nx;
         if (fill_nx >= span_lanes_i) drain_q <= 1'b1;
      end else if (wr_take_o) begin
         if (ptr_nx >= fill_q) begin
            fill_q  <= '0;
            ptr_q   <= '0;
            drain_q <= 1'b0;
         end else begin
            ptr_q <= ptr_nx;
         end
      end
   end

   assign fill_cnt_o = fill_q;
   assign rd_ptr_o   = ptr_q;
   assign draining_o = drain_q;

endmodule

// File: rtl/dpk_lane_store.sv
module dpk_lane_store
   import dpk_pkg::*;
#(
   parameter int unsigned LANE_W = 8,
   localparam int unsigned DATA_W = OPER_LANES * LANE_W,
   localparam int unsigned IDX_W  = $clog2(OPER_LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              rd_take_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic [CNT_W-1:0]  fill_cnt_i,
   input  logic [CNT_W-1:0]  src_lanes_i,
   output logic [LANE_W-1:0] lane_o [OPER_LANES]
);

   logic [LANE_W-1:0] in_lane [OPER_LANES];

   for (genvar j = 0; j < OPER_LANES; j++) begin : g_in
      assign in_lane[j] = rd_data_i[j*LANE_W +: LANE_W];
   end

   // Lane 0 is the most significant lane of the destination operand.
   for (genvar i = 0; i < OPER_LANES; i++) begin : g_lane
      localparam logic [CNT_W-1:0] LI = CNT_W'(i);
      logic [CNT_W-1:0]  offs;
      logic [CNT_W-1:0]  pick;
      logic              hit;
      logic [LANE_W-1:0] q;

      always_comb begin
         offs = LI - fill_cnt_i;
         hit  = rd_take_i && (LI >= fill_cnt_i) && (offs < src_lanes_i);
         pick = src_lanes_i - 3'd1 - offs;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q <= '0;
         else if (clear_i) q <= '0;
         else if (hit)     q <= in_lane[pick[IDX_W-1:0]];
      end

      assign lane_o[i] = q;
   end

endmodule

// File: rtl/dpk_out_mux.sv
module dpk_out_mux
   import dpk_pkg::*;
#(
   parameter int unsigned LANE_W   = 8,
   parameter bit          GATE_OUT = 1'b1,
   localparam int unsigned DATA_W = OPER_LANES * LANE_W,
   localparam int unsigned IDX_W  = $clog2(OPER_LANES)
) (
   input  logic [LANE_W-1:0] lane_i [OPER_LANES],
   input  logic [CNT_W-1:0]  rd_ptr_i,
   input  logic [CNT_W-1:0]  dst_lanes_i,
   input  logic              draining_i,
   output logic [DATA_W-1:0] wr_data_o
);

   logic [DATA_W-1:0] raw;

   for (genvar k = 0; k < OPER_LANES; k++) begin : g_out
      localparam logic [CNT_W-1:0] KI = CNT_W'(k);
      logic [CNT_W-1:0] src_idx;
      always_comb begin
         src_idx = rd_ptr_i + dst_lanes_i - 3'd1 - KI;
         raw[k*LANE_W +: LANE_W] = (KI < dst_lanes_i) ? lane_i[src_idx[IDX_W-1:0]]
                                                       : '0;
      end
   end

   if (GATE_OUT) begin : g_gated
      assign wr_data_o = draining_i ? raw : '0;
   end else begin : g_raw
      assign wr_data_o = raw;
   end

endmodule

// File: rtl/dma_pack_buf.sv
module dma_pack_buf
   import dpk_pkg::*;
#(
   parameter int unsigned LANE_W   = 8,
   parameter bit          GATE_OUT = 1'b1,
   localparam int unsigned DATA_W = OPER_LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_i,
   input  logic [1:0]        src_size_i,
   input  logic [1:0]        dst_size_i,
   input  logic              rd_valid_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              wr_accept_i,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              wr_ready_o,
   output logic              rd_req_o
);

   if (LANE_W < 1) begin : g_bad_lane
      $error("dma_pack_buf: LANE_W must be at least 1");
   end
   if (OPER_LANES != 4) begin : g_bad_lanes
      $error("dma_pack_buf: byte/word/long sizing needs four lanes");
   end

   logic [CNT_W-1:0]  src_lanes, dst_lanes, span_lanes;
   logic [CNT_W-1:0]  fill_cnt, rd_ptr;
   logic              draining, rd_take, wr_take;
   logic [LANE_W-1:0] lanes [OPER_LANES];

   dpk_size_decode u_dec (
      .src_size_i  (src_size_i),
      .dst_size_i  (dst_size_i),
      .src_lanes_o (src_lanes),
      .dst_lanes_o (dst_lanes),
      .span_lanes_o(span_lanes)
   );

   dpk_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .abort_i     (abort_i),
      .rd_valid_i  (rd_valid_i),
      .wr_accept_i (wr_accept_i),
      .src_lanes_i (src_lanes),
      .dst_lanes_i (dst_lanes),
      .span_lanes_i(span_lanes),
      .fill_cnt_o  (fill_cnt),
      .rd_ptr_o    (rd_ptr),
      .draining_o  (draining),
      .rd_take_o   (rd_take),
      .wr_take_o   (wr_take)
   );

   dpk_lane_store #(.LANE_W(LANE_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (abort_i),
      .rd_take_i  (rd_take),
      .rd_data_i  (rd_data_i),
      .fill_cnt_i (fill_cnt),
      .src_lanes_i(src_lanes),
      .lane_o     (lanes)
   );

   dpk_out_mux #(.LANE_W(LANE_W), .GATE_OUT(GATE_OUT)) u_out (
      .lane_i     (lanes),
      .rd_ptr_i   (rd_ptr),
      .dst_lanes_i(dst_lanes),
      .draining_i (draining),
      .wr_data_o  (wr_data_o)
   );

   assign wr_ready_o = draining;
   assign rd_req_o   = !draining;

   logic unused_take;
   assign unused_take = wr_take;

endmodule

// File: rtl/dma_pack_buf_chk.sv
module dma_pack_buf_chk #(
   parameter int unsigned LANE_W = 8,
   localparam int unsigned DATA_W = 4 * LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              abort_i,
   input logic [1:0]        src_size_i,
   input logic [1:0]        dst_size_i,
   input logic              rd_valid_i,
   input logic [DATA_W-1:0] rd_data_i,
   input logic              wr_accept_i,
   input logic [DATA_W-1:0] wr_data_o,
   input logic              wr_ready_o,
   input logic              rd_req_o
);

   function automatic logic [DATA_W-1:0] keep_mask(input logic [1:0] code);
      case (code)
         2'b00:   return DATA_W'({LANE_W{1'b1}});
         2'b01:   return DATA_W'({2*LANE_W{1'b1}});
         default: return {DATA_W{1'b1}};
      endcase
   endfunction

   // R3: equal sizes pass the operand through on the next cycle
   p_pass_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_i && rd_req_o && !abort_i && (src_size_i == dst_size_i))
      |=> (wr_ready_o && (wr_data_o == ($past(rd_data_i) & keep_mask($past(src_size_i))))));

   // R7: a stalled write keeps its data
   p_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ready_o && !wr_accept_i && !abort_i) |=> (wr_ready_o && $stable(wr_data_o)));

   // R7: read request persists while no data arrives
   p_read_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_valid_i && !abort_i) |=> rd_req_o);

   // R8: abort empties the buffer
   p_abort_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (rd_req_o && !wr_ready_o));

   // R2: unused write lanes of a byte destination are zero
   p_byte_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ready_o && (dst_size_i == 2'b00)) |-> (wr_data_o[DATA_W-1:LANE_W] == '0));

endmodule

bind dma_pack_buf dma_pack_buf_chk #(.LANE_W(LANE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .abort_i    (abort_i),
   .src_size_i (src_size_i),
   .dst_size_i (dst_size_i),
   .rd_valid_i (rd_valid_i),
   .rd_data_i  (rd_data_i),
   .wr_accept_i(wr_accept_i),
   .wr_data_o  (wr_data_o),
   .wr_ready_o (wr_ready_o),
   .rd_req_o   (rd_req_o)
);

// File: tb/dma_pack_buf_tb.sv
module dma_pack_buf_tb;

   localparam logic [1:0] SB = 2'b00, SW = 2'b01, SL = 2'b10, SL3 = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        abort_i = 1'b0;
   logic [1:0]  src_size_i = SB, dst_size_i = SB;
   logic        rd_valid_i = 1'b0;
   logic [31:0] rd_data_i = '0;
   logic        wr_accept_i = 1'b0;
   logic [31:0] wr_data_o;
   logic        wr_ready_o, rd_req_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dma_pack_buf u_dut (
      .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
      .src_size_i(src_size_i), .dst_size_i(dst_size_i),
      .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
      .wr_accept_i(wr_accept_i), .wr_data_o(wr_data_o),
      .wr_ready_o(wr_ready_o), .rd_req_o(rd_req_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic sizes(input logic [1:0] s, input logic [1:0] d);
      @(negedge clk);
      src_size_i = s;
      dst_size_i = d;
   endtask

   task automatic rd(input logic [31:0] d);
      @(negedge clk);
      rd_valid_i = 1'b1;
      rd_data_i  = d;
      @(negedge clk);
      rd_valid_i = 1'b0;
   endtask

   task automatic wr(input string req, input logic [31:0] exp);
      chk({req, " ready"}, 32'(wr_ready_o), 32'd1);
      chk({req, " data"}, wr_data_o, exp);
      wr_accept_i = 1'b1;
      @(negedge clk);
      wr_accept_i = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 rd_req", 32'(rd_req_o), 32'd1);
      chk("R1 wr_ready", 32'(wr_ready_o), 32'd0);
      chk("R1 wr_data", wr_data_o, 32'd0);
   endtask

   task automatic t_same;
      sizes(SL, SL);
      rd(32'hA1B2C3D4);
      chk("R6 rd_req low while full", 32'(rd_req_o), 32'd0);
      wr("R3 long pass", 32'hA1B2C3D4);
      chk("R6 rd_req back", 32'(rd_req_o), 32'd1);
      sizes(SB, SB);
      rd(32'hFFFFFF5A);
      wr("R2 R3 byte pass upper zero", 32'h0000005A);
      sizes(SL3, SL);
      rd(32'h01020304);
      wr("R2 code 11 is long", 32'h01020304);
   endtask

   task automatic t_pack;
      sizes(SB, SW);
      rd(32'h00000012);
      chk("R4 no ready after first byte", 32'(wr_ready_o), 32'd0);
      chk("R4 still requesting", 32'(rd_req_o), 32'd1);
      rd(32'hEEEEEE34);
      wr("R4 byte to word", 32'h00001234);
      sizes(SB, SL);
      rd(32'h11); rd(32'h22); rd(32'h33);
      chk("R4 not ready after three bytes", 32'(wr_ready_o), 32'd0);
      rd(32'h44);
      wr("R4 byte to long", 32'h11223344);
      sizes(SW, SL);
      rd(32'hAAAA1234);
      rd(32'h00005678);
      wr("R4 R2 word to long", 32'h12345678);
   endtask

   task automatic t_unpack;
      sizes(SL, SB);
      rd(32'hDEADBEEF);
      wr("R5 long to byte 0", 32'h000000DE);
      chk("R6 no read between writes", 32'(rd_req_o), 32'd0);
      wr("R5 long to byte 1", 32'h000000AD);
      wr("R5 long to byte 2", 32'h000000BE);
      wr("R5 long to byte 3", 32'h000000EF);
      chk("R6 read after last write", 32'(rd_req_o), 32'd1);
      chk("R5 ready drops", 32'(wr_ready_o), 32'd0);
      sizes(SL, SW);
      rd(32'hCAFEF00D);
      wr("R5 long to word hi", 32'h0000CAFE);
      wr("R5 long to word lo", 32'h0000F00D);
      sizes(SW, SB);
      rd(32'hFFFF9A7B);
      wr("R5 word to byte hi", 32'h0000009A);
      wr("R5 word to byte lo", 32'h0000007B);
   endtask

   task automatic t_stall_ignore;
      sizes(SW, SW);
      repeat (3) @(negedge clk);
      chk("R7 idle keeps rd_req", 32'(rd_req_o), 32'd1);
      wr_accept_i = 1'b1;
      @(negedge clk);
      wr_accept_i = 1'b0;
      chk("R9 stray accept no ready", 32'(wr_ready_o), 32'd0);
      rd(32'h0000BEAD);
      repeat (3) @(negedge clk);
      chk("R7 held ready", 32'(wr_ready_o), 32'd1);
      chk("R7 held data", wr_data_o, 32'h0000BEAD);
      rd(32'h00001111);
      chk("R9 stray read ignored", wr_data_o, 32'h0000BEAD);
      wr("R9 original operand", 32'h0000BEAD);
      sizes(SB, SW);
      rd(32'h77); rd(32'h88);
      wr("R9 pack after stray accept", 32'h00007788);
   endtask

   task automatic t_abort;
      sizes(SB, SL);
      rd(32'h01); rd(32'h02);
      @(negedge clk); abort_i = 1'b1;
      @(negedge clk); abort_i = 1'b0;
      chk("R8 rd_req after abort", 32'(rd_req_o), 32'd1);
      chk("R8 ready low after abort", 32'(wr_ready_o), 32'd0);
      rd(32'h55); rd(32'h66); rd(32'h77);
      chk("R8 refill not early", 32'(wr_ready_o), 32'd0);
      rd(32'h88);
      wr("R8 refill from top", 32'h55667788);
      sizes(SL, SB);
      rd(32'h9ABCDEF0);
      wr("R8 drain first", 32'h0000009A);
      @(negedge clk); abort_i = 1'b1;
      @(negedge clk); abort_i = 1'b0;
      chk("R8 drain aborted", 32'(wr_ready_o), 32'd0);
      chk("R8 drain aborted data", wr_data_o, 32'd0);
      sizes(SW, SW);
      rd(32'h00004321);
      wr("R8 clean after abort", 32'h00004321);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_same();
      t_pack();
      t_unpack();
      t_stall_ignore();
      t_abort();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule